// File: doc/BRIEF.md
# Address-Register Word Memory

This block is a word-addressed random-access store with a 16-bit data path. Storage is reached only through two internal registers: an address register and a data register. A transfer takes two steps. A load-address command first copies the bus value into the address register. A read or write command then acts on the word that the address register selects. A read places the word in the data register, and the data register drives the output bus. A write stores the bus value into the selected word.

The depth is a parameter and must be a power of two. With the default of 1024 words the block serves as a large memory, and a setting of 256 gives a smaller one. A second parameter builds a read-only variant. That variant has no storage cells: its contents are a fixed table computed from the word index, and it refuses writes. Every command cycle produces a one-cycle completion pulse in the following cycle. Commands that conflict with one another are refused and flagged.

Top module: `regaddr_mem_top`

## Requirements
- R1: After reset, `bus_out` is 0, `done` is 0, `fault` is 0 and the address register holds 0. A write issued before any address load therefore lands in word 0.
- R2: A load-address command (`cmd_load` alone) copies the low log2(DEPTH) bits of `bus_in` into the address register. Higher bits are ignored, so addresses wrap modulo DEPTH.
- R3: A write command (`cmd_write` alone, writable variant) stores `bus_in` into the addressed word. The data register also takes that value, which shows on `bus_out` in the cycle after the command.
- R4: A read command (`cmd_read` alone) copies the addressed word into the data register. The word is on `bus_out` in the cycle in which the matching `done` is high, and `bus_out` holds until the next accepted read or write.
- R5: The address register keeps its value through reads, writes and idle cycles. Repeated transfers to one location need only one address load.
- R6: `done` is high for one cycle in the cycle after every cycle in which any command input is high. It is low in the cycle after a cycle with no command.
- R7: A cycle in which `cmd_load` is high together with `cmd_read` or `cmd_write`, or in which `cmd_read` and `cmd_write` are both high, is a clash. `fault` and `done` are then high in the next cycle, and the address register, the data register and storage all stay unchanged.
- R8: With READ_ONLY=1, word i reads as (i*40503 + 4660) mod 65536.
- R9: With READ_ONLY=1, a write command raises `fault` together with `done` in the next cycle. The contents and the data register stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_in | input | 16 | Address for load commands, data for write commands |
| cmd_load | input | 1 | Load the address register from `bus_in` |
| cmd_read | input | 1 | Read the addressed word into the data register |
| cmd_write | input | 1 | Write `bus_in` into the addressed word |
| bus_out | output | 16 | Data register contents |
| done | output | 1 | One-cycle completion pulse for each command cycle |
| fault | output | 1 | Clash or refused write, high together with `done` |

## Verification
The assertions assume that `bus_in` carries no unknown bits whenever a write is accepted. They also assume that every command input is a known level at each clock edge after reset. The bench drives all inputs on the falling edge to fixed values and returns them to zero after each command. The writable memory is never read at a location the bench has not first written, so no uninitialised word reaches the comparisons. Clash cases are entered on purpose, one combination at a time, each with a known location and data register behind it so that any disturbance becomes visible.

// File: rtl/regmem_pkg.sv
package regmem_pkg;

    localparam int WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_LOAD,
        OP_READ,
        OP_WRITE,
        OP_CLASH,
        OP_DENY
    } op_e;

    typedef struct packed {
        op_e  op;
        logic fault;
        logic active;
    } cmd_t;

    // fixed contents of the read-only variant, computed from the index
    function automatic word_t rom_word(input logic [31:0] idx);
        logic [31:0] acc;
        acc = idx * 32'd40503 + 32'd4660;
        return acc[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/regmem_cmd_decode.sv
module regmem_cmd_decode
    import regmem_pkg::*;
#(
    parameter bit READ_ONLY = 1'b0
) (
    input  logic cmd_load,
    input  logic cmd_read,
    input  logic cmd_write,
    output cmd_t cmd
);

    logic clash;

    assign clash = (cmd_load && (cmd_read || cmd_write)) || (cmd_read && cmd_write);

    always_comb begin
        cmd        = '0;
        cmd.active = cmd_load | cmd_read | cmd_write;
        if (clash) begin
            cmd.op    = OP_CLASH;
            cmd.fault = 1'b1;
        end else if (cmd_load) begin
            cmd.op = OP_LOAD;
        end else if (cmd_read) begin
            cmd.op = OP_READ;
        end else if (cmd_write) begin
            if (READ_ONLY) begin
                cmd.op    = OP_DENY;
                cmd.fault = 1'b1;
            end else begin
                cmd.op = OP_WRITE;
            end
        end else begin
            cmd.op = OP_IDLE;
        end
    end

    // R7: a fault code never appears without a command behind it
    always_comb begin
        a_r7_fault_needs_cmd : assert (!cmd.fault || cmd.active);
    end

endmodule

// File: rtl/regmem_store.sv
module regmem_store
    import regmem_pkg::*;
#(
    parameter int DEPTH     = 1024,
    parameter bit READ_ONLY = 1'b0,
    parameter int AW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  word_t         wr_data,
    output word_t         rd_data
);

    generate
        if (READ_ONLY) begin : g_rom
            assign rd_data = rom_word({{(32-AW){1'b0}}, addr});

            // R9: the read-only table is never asked to store
            a_r9_rom_no_store : assert property (@(posedge clk) disable iff (rst)
                !wr_en);
        end else begin : g_ram
            word_t cells [DEPTH];

            always_ff @(posedge clk) begin
                if (wr_en) begin
                    cells[addr] <= wr_data;
                end
            end

            assign rd_data = cells[addr];

            // R3: a stored word is read back at the same location next cycle
            a_r3_store_visible : assert property (@(posedge clk) disable iff (rst)
                wr_en |=> (rd_data == $past(wr_data)) || (addr != $past(addr)));
        end
    endgenerate

    // R3: write data must be fully known when storing
    a_r3_wdata_known : assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !$isunknown(wr_data));

endmodule

// File: rtl/regmem_regs.sv
module regmem_regs
    import regmem_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  cmd_t          cmd,
    input  word_t         bus_in,
    input  word_t         rd_data,
    output logic [AW-1:0] addr_q,
    output word_t         data_q,
    output logic          wr_en,
    output logic          done_q,
    output logic          err_q
);

    assign wr_en = (cmd.op == OP_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= cmd.active;
            err_q  <= cmd.fault;
            case (cmd.op)
                OP_LOAD:  addr_q <= bus_in[AW-1:0];
                OP_READ:  data_q <= rd_data;
                OP_WRITE: data_q <= bus_in;
                default:  ;
            endcase
        end
    end

    // R5: only a load command moves the address register
    a_r5_addr_hold : assert property (@(posedge clk) disable iff (rst)
        (cmd.op != OP_LOAD) |=> $stable(addr_q));

    // R7, R9: a refused command leaves the data register alone
    a_r7_refused_keeps_data : assert property (@(posedge clk) disable iff (rst)
        cmd.fault |=> $stable(data_q));

endmodule

// File: rtl/regaddr_mem_top.sv
module regaddr_mem_top
    import regmem_pkg::*;
#(
    parameter int DEPTH     = 1024,
    parameter bit READ_ONLY = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] bus_in,
    input  logic        cmd_load,
    input  logic        cmd_read,
    input  logic        cmd_write,
    output logic [15:0] bus_out,
    output logic        done,
    output logic        fault
);

    localparam int AW = $clog2(DEPTH);

    cmd_t          cmd;
    logic [AW-1:0] addr_q;
    word_t         rd_data;
    logic          wr_en;

    regmem_cmd_decode #(
        .READ_ONLY(READ_ONLY)
    ) u_decode (
        .cmd_load (cmd_load),
        .cmd_read (cmd_read),
        .cmd_write(cmd_write),
        .cmd      (cmd)
    );

    regmem_regs #(
        .AW(AW)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .bus_in (bus_in),
        .rd_data(rd_data),
        .addr_q (addr_q),
        .data_q (bus_out),
        .wr_en  (wr_en),
        .done_q (done),
        .err_q  (fault)
    );

    regmem_store #(
        .DEPTH    (DEPTH),
        .READ_ONLY(READ_ONLY),
        .AW       (AW)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr_q),
        .wr_data(bus_in),
        .rd_data(rd_data)
    );

    // R6: every command cycle is answered by done next cycle
    a_r6_done_follows_cmd : assert property (@(posedge clk) disable iff (rst)
        (cmd_load || cmd_read || cmd_write) |=> done);

    // R6: no done without a command the cycle before
    a_r6_no_spurious_done : assert property (@(posedge clk) disable iff (rst)
        !(cmd_load || cmd_read || cmd_write) |=> !done);

    // R7: clashing commands raise the fault flag with done
    a_r7_clash_flag : assert property (@(posedge clk) disable iff (rst)
        ((cmd_load && (cmd_read || cmd_write)) || (cmd_read && cmd_write)) |=> (fault && done));

    // R4: the output only changes after a read or write
    a_r4_data_hold : assert property (@(posedge clk) disable iff (rst)
        !(cmd_read || cmd_write) |=> $stable(bus_out));

    // R6: a fault is always part of a done pulse
    a_r6_fault_in_done : assert property (@(posedge clk) disable iff (rst)
        fault |-> done);

endmodule

// File: tb/regaddr_mem_top_test.sv
`timescale 1ns/1ps
module regaddr_mem_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;

    logic [15:0] a_bin = '0;
    logic        a_ld = 0, a_rd = 0, a_wr = 0;
    logic [15:0] a_bout;
    logic        a_done, a_flt;

    logic [15:0] b_bin = '0;
    logic        b_ld = 0, b_rd = 0, b_wr = 0;
    logic [15:0] b_bout;
    logic        b_done, b_flt;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    regaddr_mem_top #(.DEPTH(1024), .READ_ONLY(1'b0)) uut (
        .clk(clk), .rst(rst), .bus_in(a_bin), .cmd_load(a_ld), .cmd_read(a_rd),
        .cmd_write(a_wr), .bus_out(a_bout), .done(a_done), .fault(a_flt)
    );

    regaddr_mem_top #(.DEPTH(256), .READ_ONLY(1'b1)) uut_rom (
        .clk(clk), .rst(rst), .bus_in(b_bin), .cmd_load(b_ld), .cmd_read(b_rd),
        .cmd_write(b_wr), .bus_out(b_bout), .done(b_done), .fault(b_flt)
    );

    function automatic logic [15:0] table_word(input int i);
        int v;
        v = (i * 40503 + 4660) % 65536;
        return v[15:0];
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one command cycle on the selected instance, return after the edge
    task automatic issue(input bit rom, input logic l, input logic r, input logic w,
                         input logic [15:0] d);
        if (rom) begin
            b_ld = l; b_rd = r; b_wr = w; b_bin = d;
        end else begin
            a_ld = l; a_rd = r; a_wr = w; a_bin = d;
        end
        @(negedge clk);
        a_ld = 0; a_rd = 0; a_wr = 0; a_bin = '0;
        b_ld = 0; b_rd = 0; b_wr = 0; b_bin = '0;
    endtask

    task automatic see(input bit rom, input string tag, input logic [15:0] d,
                       input logic dn, input logic er);
        chk({tag, " data"}, rom ? b_bout : a_bout, d);
        chk({tag, " done"}, {15'd0, rom ? b_done : a_done}, {15'd0, dn});
        chk({tag, " fault"}, {15'd0, rom ? b_flt : a_flt}, {15'd0, er});
    endtask

    task automatic t_reset();
        see(0, "R1 reset ram", 16'h0000, 0, 0);
        see(1, "R1 reset rom", 16'h0000, 0, 0);
        issue(0, 0, 0, 1, 16'hDEAD);            // no load: goes to word 0
        see(0, "R1 write before load", 16'hDEAD, 1, 0);
        issue(0, 1, 0, 0, 16'h0000);
        issue(0, 0, 1, 0, 16'h0000);
        see(0, "R1 word0 readback", 16'hDEAD, 1, 0);
    endtask

    task automatic t_write_read();
        issue(0, 1, 0, 0, 16'd5);
        see(0, "R2 load keeps data", 16'hDEAD, 1, 0);
        issue(0, 0, 0, 1, 16'hA5A5);
        see(0, "R3 write echo", 16'hA5A5, 1, 0);
        issue(0, 1, 0, 0, 16'd6);
        issue(0, 0, 0, 1, 16'h1234);
        issue(0, 1, 0, 0, 16'd5);
        issue(0, 0, 1, 0, 16'h0000);
        see(0, "R4 read word5", 16'hA5A5, 1, 0);
        issue(0, 1, 0, 0, 16'd6);
        issue(0, 0, 1, 0, 16'h0000);
        see(0, "R4 read word6", 16'h1234, 1, 0);
        @(negedge clk);
        see(0, "R4 R6 idle hold", 16'h1234, 0, 0);
    endtask

    task automatic t_hold();
        issue(0, 1, 0, 0, 16'd100);
        issue(0, 0, 0, 1, 16'h0001);
        issue(0, 0, 0, 1, 16'h0002);
        issue(0, 0, 0, 1, 16'h0003);
        issue(0, 0, 1, 0, 16'h0000);
        see(0, "R5 last write wins", 16'h0003, 1, 0);
        issue(0, 0, 1, 0, 16'h0000);
        see(0, "R5 R6 back-to-back read", 16'h0003, 1, 0);
        repeat (3) @(negedge clk);
        issue(0, 0, 1, 0, 16'h0000);
        see(0, "R5 after idle", 16'h0003, 1, 0);
    endtask

    task automatic t_wrap();
        issue(0, 1, 0, 0, 16'hFC07);            // low 10 bits -> 7
        issue(0, 0, 0, 1, 16'hBEEF);
        issue(0, 1, 0, 0, 16'd7);
        issue(0, 0, 1, 0, 16'h0000);
        see(0, "R2 wrap high bits", 16'hBEEF, 1, 0);
        issue(0, 1, 0, 0, 16'h0407);
        issue(0, 0, 1, 0, 16'h0000);
        see(0, "R2 wrap alias", 16'hBEEF, 1, 0);
    endtask

    task automatic t_clash();
        issue(0, 1, 0, 0, 16'd9);
        issue(0, 0, 0, 1, 16'h1111);
        issue(0, 1, 0, 0, 16'd10);
        issue(0, 0, 0, 1, 16'h2222);
        issue(0, 1, 0, 0, 16'd9);
        issue(0, 0, 1, 0, 16'h0000);
        see(0, "R7 setup", 16'h1111, 1, 0);
        issue(0, 1, 1, 0, 16'd10);
        see(0, "R7 load+read", 16'h1111, 1, 1);
        issue(0, 0, 1, 0, 16'h0000);
        see(0, "R7 addr kept after load+read", 16'h1111, 1, 0);
        issue(0, 1, 0, 1, 16'h3333);
        see(0, "R7 load+write", 16'h1111, 1, 1);
        issue(0, 0, 1, 1, 16'h4444);
        see(0, "R7 read+write", 16'h1111, 1, 1);
        issue(0, 1, 1, 1, 16'h5555);
        see(0, "R7 all three", 16'h1111, 1, 1);
        issue(0, 0, 1, 0, 16'h0000);
        see(0, "R7 word9 untouched", 16'h1111, 1, 0);
        issue(0, 1, 0, 0, 16'd10);
        issue(0, 0, 1, 0, 16'h0000);
        see(0, "R7 word10 untouched", 16'h2222, 1, 0);
    endtask

    task automatic t_rom();
        issue(1, 1, 0, 0, 16'd3);
        issue(1, 0, 1, 0, 16'h0000);
        see(1, "R8 word3", table_word(3), 1, 0);
        issue(1, 1, 0, 0, 16'h01FF);            // 256 deep -> 255
        issue(1, 0, 1, 0, 16'h0000);
        see(1, "R8 R2 word255 wrap", table_word(255), 1, 0);
        issue(1, 0, 0, 1, 16'h0000);
        see(1, "R9 write refused", table_word(255), 1, 1);
        issue(1, 0, 1, 0, 16'h0000);
        see(1, "R9 contents kept", table_word(255), 1, 0);
        issue(1, 1, 0, 0, 16'd0);
        issue(1, 0, 1, 0, 16'h0000);
        see(1, "R8 word0", table_word(0), 1, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_hold();
        t_wrap();
        t_clash();
        t_rom();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule